// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer Bank

This block is a memory-mapped peripheral with a parameterised number of channels (four by default). Each channel is a 32-bit down-counter that advances on a shared tick-enable input. When the count reaches zero, the next tick reloads it from a per-channel reload register and bumps a per-channel wrap counter. Because the count falls, the elapsed tick count is the bitwise inverse of the count when the reload value is all ones.

A single enable bit in a top control register gates every channel. Each channel also has its own enable. Setting a channel's enable restarts it from its reload value with the wrap counter at zero. Clearing the enable freezes the count where it is.

Software reads a channel in a fixed order, wrap counter first and count second. The wrap-counter read captures the live count into a holding register, and count reads return that held copy, so the two values form a coherent pair. Each channel raises its interrupt line when its sticky status bit is set and its mask bit is 1.

Top module: `dctimer_bank`

## Requirements
- R1: After reset, every readable register returns 0, except the revision register, and all interrupt lines are low.
- R2: A read at offset 0x10 returns the REVISION parameter. Writes there have no effect.
- R3: A channel's count falls by one on each cycle that has tick=1, while the global enable (offset 0x00, bit 0) and the channel enable (group offset 0x00, bit 0) are both 1. Otherwise the count holds.
- R4: A tick that finds the count at 0 loads the reload value (group offset 0x04), increments the wrap counter and sets status bit 0 (group offset 0x10).
- R5: A write that takes the channel enable from 0 to 1 loads the count from the reload value and zeroes the wrap counter. Load beats a tick in the same cycle.
- R6: Reading the wrap counter (group offset 0x0C) returns it and captures the count. Reads of the count (group offset 0x08) return the captured value until the next wrap-counter read.
- R7: Writing 1 to bit 0 of group offset 0x14 clears status bit 0. A wrap in the same cycle leaves the status set.
- R8: Interrupt line i equals status bit 0 of channel i AND mask bit 0 (group offset 0x18).
- R9: Channel i's register group starts at 0x20*(i+1). Channels run independently.
- R10: Reads of unmapped or unaligned offsets return 0, and writes there change nothing.
- R11: Read data appears on rdata the cycle after rd_en and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-enable pulse shared by all channels |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 4 | Per-channel interrupt lines |

## Verification
The assertions assume that wr_en and rd_en are never high in the same cycle. They also assume that a reload value is written only while its channel is disabled. The bench's bus tasks issue one access at a time and always clear the channel enable before writing a reload. Ticks go to a channel only after its restart, so the counts and wrap totals follow the arithmetic of reload R and n ticks: wraps = n/(R+1) and count = R - n mod (R+1).

// File: rtl/dctimer_pkg.sv
package dctimer_pkg;
    typedef enum logic [2:0] {
        FLD_CFG, FLD_RELOAD, FLD_COUNT, FLD_WRAPS,
        FLD_STATUS, FLD_CLEAR, FLD_MASK, FLD_NONE
    } fld_e;

    typedef struct packed {
        logic ctrl;
        logic rev;
        logic chan;
        fld_e fld;
    } dec_t;

    function automatic fld_e fld_of(input logic [4:0] off);
        case (off)
            5'h00:   return FLD_CFG;
            5'h04:   return FLD_RELOAD;
            5'h08:   return FLD_COUNT;
            5'h0C:   return FLD_WRAPS;
            5'h10:   return FLD_STATUS;
            5'h14:   return FLD_CLEAR;
            5'h18:   return FLD_MASK;
            default: return FLD_NONE;
        endcase
    endfunction
endpackage

// File: rtl/dctimer_decode.sv
module dctimer_decode
    import dctimer_pkg::*;
#(
    parameter int AW = 8,
    parameter int NCH = 4,
    localparam int GW = AW - 5
) (
    input  logic [AW-1:0]  addr,
    output dec_t           dec,
    output logic [NCH-1:0] sel
);
    logic [GW-1:0] grp;
    assign grp = addr[AW-1:5];

    always_comb begin
        dec      = '{ctrl: 1'b0, rev: 1'b0, chan: 1'b0, fld: FLD_NONE};
        sel      = '0;
        if (grp == '0) begin
            dec.ctrl = (addr[4:0] == 5'h00);
            dec.rev  = (addr[4:0] == 5'h10);
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (32'(grp) == i + 1) sel[i] = 1'b1;
            end
            dec.fld  = fld_of(addr[4:0]);
            dec.chan = (sel != '0) && (dec.fld != FLD_NONE);
        end
    end
endmodule

// File: rtl/dctimer_chan.sv
module dctimer_chan
    import dctimer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         glb_en,
    input  logic         wr,
    input  logic         rd,
    input  fld_e         fld,
    input  logic [W-1:0] wdata,
    output logic         loc_en,
    output logic [W-1:0] reload,
    output logic [W-1:0] cnt,
    output logic [W-1:0] held,
    output logic [W-1:0] wraps,
    output logic         status,
    output logic         mask
);
    logic start, step, wrap, clr, snap;

    assign start = wr && fld == FLD_CFG && wdata[0] && !loc_en;
    assign step  = tick && glb_en && loc_en && !start;
    assign wrap  = step && cnt == '0;
    assign clr   = wr && fld == FLD_CLEAR && wdata[0];
    assign snap  = rd && fld == FLD_WRAPS;

    always_ff @(posedge clk) begin
        if (rst) begin
            loc_en <= 1'b0;
            reload <= '0;
            cnt    <= '0;
            held   <= '0;
            wraps  <= '0;
            status <= 1'b0;
            mask   <= 1'b0;
        end else begin
            if (wr && fld == FLD_CFG)    loc_en <= wdata[0];
            if (wr && fld == FLD_RELOAD) reload <= wdata;
            if (wr && fld == FLD_MASK)   mask   <= wdata[0];
            if (start)                   cnt <= reload;
            else if (wrap)               cnt <= reload;
            else if (step)               cnt <= cnt - 1'b1;
            if (start)                   wraps <= '0;
            else if (wrap)               wraps <= wraps + 1'b1;
            if (wrap)                    status <= 1'b1;
            else if (clr)                status <= 1'b0;
            if (snap)                    held <= cnt;
        end
    end

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (tick && glb_en && loc_en && !start && cnt != '0) |=> cnt == $past(cnt) - 1'b1); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!(tick && glb_en && loc_en) && !start) |=> $stable(cnt)); // R3
    AST_WRAP_EVT: assert property (@(posedge clk) disable iff (rst)
        (tick && glb_en && loc_en && !start && cnt == '0) |=>
        (status && cnt == $past(reload) && wraps == $past(wraps) + 1'b1)); // R4
    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        start |=> (cnt == $past(reload) && wraps == '0)); // R5
    AST_SNAP_KEEP: assert property (@(posedge clk) disable iff (rst)
        !snap |=> $stable(held)); // R6
endmodule

// File: rtl/dctimer_bank.sv
module dctimer_bank
    import dctimer_pkg::*;
#(
    parameter int          NCH = 4,
    parameter int          W = 32,
    parameter int          AW = 8,
    parameter logic [31:0] REVISION = 32'h0001_0200
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [AW-1:0]  addr,
    input  logic [W-1:0]   wdata,
    output logic [W-1:0]   rdata,
    output logic [NCH-1:0] irq
);
    dec_t           dec;
    logic [NCH-1:0] sel;
    logic           glb_en;
    logic [NCH-1:0] loc_en, status, mask;
    logic [W-1:0]   reload [NCH];
    logic [W-1:0]   cnt    [NCH];
    logic [W-1:0]   held   [NCH];
    logic [W-1:0]   wraps  [NCH];
    logic [W-1:0]   rmux;

    dctimer_decode #(.AW(AW), .NCH(NCH)) u_dec (.addr(addr), .dec(dec), .sel(sel));

    always_ff @(posedge clk) begin
        if (rst) glb_en <= 1'b0;
        else if (wr_en && dec.ctrl) glb_en <= wdata[0];
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dctimer_chan #(.W(W)) u_ch (
            .clk(clk), .rst(rst), .tick(tick), .glb_en(glb_en),
            .wr(wr_en && dec.chan && sel[i]), .rd(rd_en && dec.chan && sel[i]),
            .fld(dec.fld), .wdata(wdata),
            .loc_en(loc_en[i]), .reload(reload[i]), .cnt(cnt[i]), .held(held[i]),
            .wraps(wraps[i]), .status(status[i]), .mask(mask[i])
        );
        assign irq[i] = status[i] & mask[i];
    end

    always_comb begin
        rmux = '0;
        if (dec.ctrl) rmux = W'(glb_en);
        else if (dec.rev) rmux = W'(REVISION);
        else if (dec.chan) begin
            for (int i = 0; i < NCH; i++) begin
                if (sel[i]) begin
                    case (dec.fld)
                        FLD_CFG:    rmux = W'(loc_en[i]);
                        FLD_RELOAD: rmux = reload[i];
                        FLD_COUNT:  rmux = held[i];
                        FLD_WRAPS:  rmux = wraps[i];
                        FLD_STATUS: rmux = W'(status[i]);
                        FLD_MASK:   rmux = W'(mask[i]);
                        default:    rmux = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else if (rd_en) rdata <= rmux;
    end

    AST_REV_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == AW'(8'h10)) |=> rdata == W'(REVISION)); // R2
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata)); // R11
    AST_ONE_SEL: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel)); // R9
endmodule

// File: tb/dctimer_bank_tb.sv
module dctimer_bank_tb;
    localparam int NCH = 4;
    localparam logic [31:0] REV = 32'h0001_0200;

    logic        clk = 1'b0, rst = 1'b1, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic [3:0]  irq;
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    dctimer_bank #(.NCH(NCH), .REVISION(REV)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic tk = 1'b0);
        wr_en = 1'b1; addr = a; wdata = d; tick = tk;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1; @(negedge clk);
        end
        tick = 1'b0;
    endtask

    function automatic logic [7:0] gb(input int ch);
        return 8'((ch + 1) * 32);
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 irq", 32'(irq), 0);
        rd(8'h00, v); chk("R1 ctrl", v, 0);
        for (int c = 0; c < NCH; c++) begin
            rd(gb(c) + 8'h0C, v); chk("R1 wraps", v, 0);
            rd(gb(c) + 8'h08, v); chk("R1 count", v, 0);
            rd(gb(c) + 8'h10, v); chk("R1 status", v, 0);
        end
        rd(8'h10, v); chk("R2 rev", v, REV);
        wr(8'h10, 32'hDEAD_BEEF);
        rd(8'h10, v); chk("R2 rev write ignored", v, REV);
        // R11: rdata holds between reads
        repeat (3) @(negedge clk);
        chk("R11 hold", rdata, REV);

        // R3: global enable off blocks ticks
        wr(gb(0) + 8'h04, 32'd50); wr(gb(0), 1);
        ticks(5);
        rd(gb(0) + 8'h0C, v); rd(gb(0) + 8'h08, v); chk("R3 global off", v, 50);
        wr(8'h00, 1);
        wr(gb(0), 0);

        // R3 R4 R5 R9: sweep of reload and tick counts per channel
        for (int c = 0; c < NCH; c++) begin
            for (int r = 0; r < 4; r++) begin
                for (int n = 0; n < 10; n += 3) begin
                    wr(gb(c), 0);
                    wr(gb(c) + 8'h04, 32'(r));
                    wr(gb(c), 1);
                    ticks(n);
                    rd(gb(c) + 8'h0C, w);
                    rd(gb(c) + 8'h08, v);
                    chk("R4 wraps", w, 32'(n / (r + 1)));
                    chk("R3 count", v, 32'(r - n % (r + 1)));
                end
            end
            wr(gb(c), 0);
            // R3: disabled channel holds
            ticks(4);
            rd(gb(c) + 8'h0C, w); rd(gb(c) + 8'h08, w); chk("R3 local off hold", w, v);
        end
        // R9: channels independent, only channel 2 runs
        wr(gb(1) + 8'h04, 32'd7); wr(gb(1), 1); wr(gb(1), 0);
        wr(gb(2) + 8'h04, 32'd7); wr(gb(2), 1);
        ticks(3);
        rd(gb(2) + 8'h0C, v); rd(gb(2) + 8'h08, v); chk("R9 chan2 runs", v, 4);
        rd(gb(1) + 8'h0C, v); rd(gb(1) + 8'h08, v); chk("R9 chan1 still", v, 7);
        // R5: load beats a tick in the enabling cycle
        wr(gb(1), 1, 1'b1);
        rd(gb(1) + 8'h0C, v); chk("R5 wraps zeroed", v, 0);
        rd(gb(1) + 8'h08, v); chk("R5 load over tick", v, 7);
        // R6: captured count survives later ticks
        ticks(2);
        rd(gb(1) + 8'h0C, v);
        ticks(3);
        rd(gb(1) + 8'h08, v); chk("R6 captured", v, 5);
        rd(gb(1) + 8'h0C, v); rd(gb(1) + 8'h08, v); chk("R6 recapture", v, 2);

        // R7 R8: status, clear, mask on channel 3 with reload 0
        wr(gb(3), 0); wr(gb(3) + 8'h04, 0); wr(gb(3), 1);
        ticks(1);
        rd(gb(3) + 8'h10, v); chk("R4 status set", v, 1);
        chk("R8 masked irq", 32'(irq[3]), 0);
        wr(gb(3) + 8'h18, 1);
        chk("R8 irq on", 32'(irq[3]), 1);
        wr(gb(3) + 8'h14, 1, 1'b1);
        rd(gb(3) + 8'h10, v); chk("R7 wrap beats clear", v, 1);
        wr(gb(3) + 8'h14, 1);
        rd(gb(3) + 8'h10, v); chk("R7 cleared", v, 0);
        chk("R8 irq off", 32'(irq[3]), 0);
        rd(gb(3) + 8'h14, v); chk("R10 clear reads 0", v, 0);

        // R10: unmapped and unaligned
        wr(8'hA0, 32'h1234); wr(gb(0) + 8'h1C, 5); wr(gb(0) + 8'h05, 9);
        rd(8'hA0, v); chk("R10 beyond groups", v, 0);
        rd(gb(0) + 8'h05, v); chk("R10 unaligned", v, 0);
        rd(8'h04, v); chk("R10 top hole", v, 0);
        rd(gb(0) + 8'h04, v); chk("R10 reload untouched", v, 3);
        rd(8'h00, v); chk("R10 ctrl untouched", v, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule